// File: doc/BRIEF.md
# Block Move and Compare Engine

This engine performs one step of a byte-oriented block operation over memory. A step either copies one byte from the source pointer to the destination pointer, or compares the byte at the source pointer against an accumulator value. It also advances the pointers in the chosen direction and counts the length register down by one. The instruction sequencer supplies the source pointer, destination pointer, length count, accumulator and current flag byte with a one-cycle start pulse. When the step finishes, the engine returns the updated pointers, count and flag byte, together with a rewind indication.

The engine never loops by itself. For the repeating forms, the rewind output tells the sequencer to move its program counter back by two, so the same instruction is fetched again and the engine starts a new step. Between steps the sequencer can service interrupts or stall.

The flag byte uses the layout S=bit 7, Z=bit 6, Y=bit 5, H=bit 4, X=bit 3, P/V=bit 2, N=bit 1, C=bit 0. Memory is a synchronous byte port: read data arrives on the cycle after the read strobe.

Top module: `blkXferEngine`

## Requirements
- R1: After reset the engine is idle, with busy, done, memRd and memWr low, and hlOut, deOut, bcOut, flagsOut and rewind all zero.
- R2: A move step (isCompare=0) reads the byte at hlIn and then writes that byte to address deIn.
- R3: At the end of a step, hlOut is hlIn plus 1 (goDown=0) or minus 1 (goDown=1). For a move, deOut is deIn stepped the same way. bcOut is bcIn minus 1, modulo 2^CW.
- R4: Move flags: H=0 and N=0. P/V is 1 when bcOut is nonzero. Y is bit 1 and X is bit 3 of the 8-bit sum of the byte and accIn. S, Z and C keep their flagsIn values.
- R5: Compare flags, with d = accIn minus byte (8 bits) and h = (accIn[3:0] < byte[3:0]): S=d[7], Z=(d==0), H=h, N=1, P/V=(bcOut!=0). Y is bit 1 and X is bit 3 of (d - h). C keeps its flagsIn value.
- R6: A compare step (isCompare=1) performs no memory write, and deOut equals deIn.
- R7: For a move, rewind is 1 exactly when repeatOp=1 and bcOut is nonzero.
- R8: For a compare, rewind is 1 exactly when repeatOp=1, bcOut is nonzero and d is nonzero.
- R9: The start pulse is followed by one read cycle and one latch cycle. A move then has one write cycle. The final cycle of the step raises done for one cycle, so a move takes 4 cycles from start to done and a compare takes 3. The engine is idle on the next cycle.
- R10: A start pulse or input change while busy has no effect on the step in progress.
- R11: A step with bcIn=0 returns bcOut=16'hFFFF. With repeatOp=1 it returns rewind=1, so a repeating operation started at zero runs 65536 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a step when idle |
| isCompare | input | 1 | 1 = compare step, 0 = move step |
| goDown | input | 1 | 1 = pointers decrement, 0 = increment |
| repeatOp | input | 1 | Repeating form of the operation |
| hlIn | input | AW | Source pointer |
| deIn | input | AW | Destination pointer |
| bcIn | input | CW | Length count |
| accIn | input | 8 | Accumulator value |
| flagsIn | input | 8 | Flag byte before the step |
| memAddr | output | AW | Memory address |
| memRd | output | 1 | Read strobe; data expected next cycle |
| memWr | output | 1 | Write strobe |
| memWData | output | 8 | Write data |
| memRData | input | 8 | Read data |
| hlOut | output | AW | Updated source pointer |
| deOut | output | AW | Updated destination pointer |
| bcOut | output | CW | Updated count |
| flagsOut | output | 8 | Updated flag byte |
| rewind | output | 1 | Sequencer must move its program counter back by two |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle end-of-step pulse |

## Verification
The assertions assume that memory returns read data on the cycle after memRd, and that the caller holds start low while done is high. The bench's memory model returns data exactly one cycle after each read. Its step task drops start after a single cycle. Each extra start it injects is timed inside the busy window, so the only starts seen outside a step are the legitimate ones. Addresses are random over the full pointer width, but the memory model decodes only the low eight bits. For that reason the expected values use the same aliasing.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LATCH,
    ST_WRITE,
    ST_FINISH
  } engState_t;

  typedef struct packed {
    logic load;
    logic rdEn;
    logic latch;
    logic wrEn;
    logic fin;
  } engCtl_t;
endpackage

// File: rtl/blkx_flags.sv
module blkx_flags
  import blkx_pkg::*;
(
  input  logic          cmpMode,
  input  logic [DW-1:0] dataByte,
  input  logic [DW-1:0] accVal,
  input  logic [DW-1:0] oldFlags,
  input  logic          countLive,
  output logic [DW-1:0] newFlags,
  output logic          diffZero
);
  logic [DW-1:0] diff, adj, sum;
  logic halfBorrow;

  always_comb begin
    diff       = accVal - dataByte;
    halfBorrow = accVal[3:0] < dataByte[3:0];
    adj        = diff - DW'(halfBorrow);
    sum        = accVal + dataByte;
    diffZero   = (diff == '0);
    if (cmpMode) begin
      // S Z Y H X P N C
      newFlags = {diff[7], diffZero, adj[1], halfBorrow, adj[3], countLive, 1'b1, oldFlags[0]};
    end else begin
      newFlags = {oldFlags[7], oldFlags[6], sum[1], 1'b0, sum[3], countLive, 1'b0, oldFlags[0]};
    end
  end
endmodule

// File: rtl/blkx_ctrl.sv
module blkx_ctrl
  import blkx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cmpMode,
  output engCtl_t ctl,
  output logic    busy
);
  engState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load  = 1'b1;
        stateNext = ST_READ;
      end
      ST_READ: begin
        ctl.rdEn  = 1'b1;
        stateNext = ST_LATCH;
      end
      ST_LATCH: begin
        ctl.latch = 1'b1;
        stateNext = cmpMode ? ST_FINISH : ST_WRITE;
      end
      ST_WRITE: begin
        ctl.wrEn  = 1'b1;
        stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        ctl.fin   = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/blkx_datapath.sv
module blkx_datapath
  import blkx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  engCtl_t       ctl,
  input  logic          isCompare,
  input  logic          goDown,
  input  logic          repeatOp,
  input  logic [AW-1:0] hlIn,
  input  logic [AW-1:0] deIn,
  input  logic [CW-1:0] bcIn,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] flagsIn,
  input  logic [DW-1:0] memRData,
  output logic          cmpMode,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] memWData,
  output logic          done,
  output logic [AW-1:0] hlOut,
  output logic [AW-1:0] deOut,
  output logic [CW-1:0] bcOut,
  output logic [DW-1:0] flagsOut,
  output logic          rewind
);
  logic [AW-1:0] hlW, deW, ptrStep;
  logic [CW-1:0] bcW, bcNext;
  logic [DW-1:0] accW, flgW, byteReg, flagNext;
  logic downW, repW, bcLive, diffZero, rewindNext;

  assign ptrStep    = downW ? {AW{1'b1}} : AW'(1);
  assign bcNext     = bcW - CW'(1);
  assign bcLive     = |bcNext;
  assign rewindNext = repW & bcLive & (~cmpMode | ~diffZero);

  blkx_flags u_flags (
    .cmpMode  (cmpMode),
    .dataByte (memRData),
    .accVal   (accW),
    .oldFlags (flgW),
    .countLive(bcLive),
    .newFlags (flagNext),
    .diffZero (diffZero)
  );

  // working copies, captured on the accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hlW <= '0; deW <= '0; bcW <= '0; accW <= '0; flgW <= '0;
      cmpMode <= 1'b0; downW <= 1'b0; repW <= 1'b0;
    end else if (ctl.load) begin
      hlW <= hlIn; deW <= deIn; bcW <= bcIn; accW <= accIn; flgW <= flagsIn;
      cmpMode <= isCompare; downW <= goDown; repW <= repeatOp;
    end
  end

  // results, committed when the read byte arrives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg <= '0; hlOut <= '0; deOut <= '0; bcOut <= '0;
      flagsOut <= '0; rewind <= 1'b0;
    end else if (ctl.latch) begin
      byteReg  <= memRData;
      hlOut    <= hlW + ptrStep;
      deOut    <= cmpMode ? deW : deW + ptrStep;
      bcOut    <= bcNext;
      flagsOut <= flagNext;
      rewind   <= rewindNext;
    end
  end

  assign memAddr  = ctl.rdEn ? hlW : deW;
  assign memWData = byteReg;
  assign memRd    = ctl.rdEn;
  assign memWr    = ctl.wrEn;
  assign done     = ctl.fin;
endmodule

// File: rtl/blkXferEngine.sv
module blkXferEngine
  import blkx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          isCompare,
  input  logic          goDown,
  input  logic          repeatOp,
  input  logic [AW-1:0] hlIn,
  input  logic [AW-1:0] deIn,
  input  logic [CW-1:0] bcIn,
  input  logic [7:0]    accIn,
  input  logic [7:0]    flagsIn,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [7:0]    memWData,
  input  logic [7:0]    memRData,
  output logic [AW-1:0] hlOut,
  output logic [AW-1:0] deOut,
  output logic [CW-1:0] bcOut,
  output logic [7:0]    flagsOut,
  output logic          rewind,
  output logic          busy,
  output logic          done
);
  engCtl_t ctl;
  logic cmpMode;

  blkx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmpMode(cmpMode),
    .ctl(ctl), .busy(busy)
  );

  blkx_datapath #(.AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .isCompare(isCompare), .goDown(goDown), .repeatOp(repeatOp),
    .hlIn(hlIn), .deIn(deIn), .bcIn(bcIn), .accIn(accIn), .flagsIn(flagsIn),
    .memRData(memRData), .cmpMode(cmpMode),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWData(memWData),
    .done(done), .hlOut(hlOut), .deOut(deOut), .bcOut(bcOut),
    .flagsOut(flagsOut), .rewind(rewind)
  );
endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          isCompare,
  input logic [AW-1:0] hlIn,
  input logic [CW-1:0] bcIn,
  input logic [AW-1:0] memAddr,
  input logic          memRd,
  input logic          memWr,
  input logic [CW-1:0] bcOut,
  input logic [7:0]    flagsOut,
  input logic          rewind,
  input logic          busy,
  input logic          done
);
  logic [AW-1:0] hlCap;
  logic [CW-1:0] bcCap;
  logic          cmpCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hlCap <= '0; bcCap <= '0; cmpCap <= 1'b0;
    end else if (start && !busy) begin
      hlCap <= hlIn; bcCap <= bcIn; cmpCap <= isCompare;
    end
  end

  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  p_read_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> memAddr == hlCap);
  p_count_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> bcOut == bcCap - CW'(1));
  p_pv_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> flagsOut[2] == (bcOut != '0));
  p_cmp_n_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> flagsOut[1] == cmpCap);
  p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmpCap) |-> !memWr);
  p_rewind_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && rewind) |-> bcOut != '0);
  p_cmp_rewind_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && cmpCap && rewind) |-> !flagsOut[6]);
  p_write_then_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> done);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  p_read_then_idle_bus_r9: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd && !memWr);
endmodule

bind blkXferEngine blkx_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .isCompare(isCompare),
  .hlIn(hlIn), .bcIn(bcIn), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
  .bcOut(bcOut), .flagsOut(flagsOut), .rewind(rewind), .busy(busy), .done(done)
);

// File: tb/blkXferEngine_test.sv
`timescale 1ns/1ps
module blkXferEngine_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, isCompare = 1'b0, goDown = 1'b0, repeatOp = 1'b0;
  logic [15:0] hlIn = '0, deIn = '0, bcIn = '0;
  logic [7:0]  accIn = '0, flagsIn = '0;
  logic [15:0] memAddr, hlOut, deOut, bcOut;
  logic        memRd, memWr, rewind, busy, done;
  logic [7:0]  memWData, memRData, flagsOut;
  logic [7:0]  mem [0:255];
  logic [7:0]  rdq = '0;
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  blkXferEngine uut (
    .clk(clk), .rstN(rstN), .start(start), .isCompare(isCompare), .goDown(goDown),
    .repeatOp(repeatOp), .hlIn(hlIn), .deIn(deIn), .bcIn(bcIn), .accIn(accIn),
    .flagsIn(flagsIn), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWData(memWData), .memRData(memRData), .hlOut(hlOut), .deOut(deOut),
    .bcOut(bcOut), .flagsOut(flagsOut), .rewind(rewind), .busy(busy), .done(done)
  );

  assign memRData = rdq;
  always @(posedge clk) begin
    if (memRd) rdq <= mem[memAddr[7:0]];
    if (memWr) mem[memAddr[7:0]] <= memWData;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expFlags(input bit cmp, input logic [7:0] b,
      input logic [7:0] a, input logic [7:0] f, input bit live);
    logic [7:0] d, t, s;
    bit h;
    d = a - b;
    h = a[3:0] < b[3:0];
    t = d - {7'b0, h};
    s = a + b;
    if (cmp) return {d[7], d == 8'h00, t[1], h, t[3], live, 1'b1, f[0]};
    return {f[7], f[6], s[1], 1'b0, s[3], live, 1'b0, f[0]};
  endfunction

  task automatic runStep(input bit cmp, input bit dn, input bit rp,
      input logic [15:0] hl, input logic [15:0] de, input logic [15:0] bc,
      input logic [7:0] a, input logic [7:0] f, input bit intrude);
    logic [7:0] b, deOld, eF;
    logic [15:0] eHl, eDe, eBc;
    bit eRw;
    int cyc;
    b     = mem[hl[7:0]];
    deOld = mem[de[7:0]];
    eHl   = dn ? hl - 16'd1 : hl + 16'd1;
    eDe   = cmp ? de : (dn ? de - 16'd1 : de + 16'd1);
    eBc   = bc - 16'd1;
    eF    = expFlags(cmp, b, a, f, eBc != 0);
    eRw   = rp && (eBc != 0) && (!cmp || (a != b));
    @(negedge clk);
    isCompare = cmp; goDown = dn; repeatOp = rp;
    hlIn = hl; deIn = de; bcIn = bc; accIn = a; flagsIn = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 10) begin
      if (intrude && cyc == 1) begin
        start = 1'b1; isCompare = ~cmp; goDown = ~dn; repeatOp = ~rp;
        hlIn = ~hl; deIn = ~de; bcIn = ~bc; accIn = ~a; flagsIn = ~f;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == (cmp ? 3 : 4), "R9", "cycles to done", cyc, cmp ? 3 : 4);
    check(hlOut == eHl, intrude ? "R10" : "R3", "hlOut", hlOut, eHl);
    check(deOut == eDe, cmp ? "R6" : "R3", "deOut", deOut, eDe);
    check(bcOut == eBc, (bc == 0) ? "R11" : "R3", "bcOut", bcOut, eBc);
    check(flagsOut == eF, cmp ? "R5" : "R4", "flagsOut", flagsOut, eF);
    check(rewind == eRw, cmp ? "R8" : "R7", "rewind", rewind, eRw);
    if (cmp) check(mem[de[7:0]] == deOld, "R6", "dest byte", mem[de[7:0]], deOld);
    else     check(mem[de[7:0]] == b, "R2", "dest byte", mem[de[7:0]], b);
    @(negedge clk);
    check(!busy && !done, "R9", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog expired: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRd && !memWr, "R1", "control idle",
          {busy, done, memRd, memWr}, 0);
    check(hlOut == 0 && deOut == 0 && bcOut == 0 && flagsOut == 0 && !rewind,
          "R1", "outputs zero", {hlOut, bcOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R11: zero count wraps, repeat continues
    runStep(0, 0, 1, 16'h1234, 16'h5678, 16'h0000, 8'h11, 8'hFF, 0);
    runStep(1, 1, 1, 16'h2000, 16'h0000, 16'h0000, 8'h00, 8'h00, 0);
    // R7: last iteration of a repeating move stops
    runStep(0, 1, 1, 16'h0000, 16'h0001, 16'h0001, 8'h80, 8'hC1, 0);
    // R8: match stops a repeating compare
    mem[8'h40] = 8'h5A;
    runStep(1, 0, 1, 16'h0040, 16'hAAAA, 16'h0005, 8'h5A, 8'h01, 0);
    // R8: non-repeating compare never rewinds
    runStep(1, 0, 0, 16'h0041, 16'hBBBB, 16'h0005, ~mem[8'h41], 8'h00, 0);
    // R5: half-borrow case
    mem[8'h50] = 8'h0F;
    runStep(1, 1, 1, 16'h0050, 16'h0000, 16'h0003, 8'h10, 8'h00, 0);
    // R10: intruding start while busy
    runStep(0, 0, 1, 16'h0060, 16'h0070, 16'h0009, 8'h33, 8'h40, 1);
    runStep(1, 1, 1, 16'h0061, 16'h0071, 16'h0009, 8'h34, 8'h80, 1);

    for (int i = 0; i < 200; i++) begin
      runStep($urandom % 2, $urandom % 2, $urandom % 2,
              16'($urandom), 16'($urandom), 16'($urandom % 4),
              8'($urandom), 8'($urandom), ($urandom % 8) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule